// File: doc/BRIEF.md
# Rate-1/2 Accumulate-Repeat-Accumulate Encoder

This block encodes a stream of information bits into codewords of a rate-1/2 accumulate-repeat-accumulate code with a fixed block length of K bits. Bits enter one at a time on a valid/ready input and are collected into a block buffer. As each bit is stored, a running-XOR precoder computes a punctured value for it. Once K bits are held, the input stalls. The codeword then leaves on a valid/ready output, one bit per accepted beat.

The first K beats of the codeword carry the information bits unchanged. The next K beats carry parity. Each precoded bit is used three times. The three copies form three sub-blocks of length K, and each sub-block is rotated by its own fixed circulant offset. A second running-XOR accumulator folds this 3K-bit interleaved stream together, and every third value it produces becomes a parity bit. Both accumulators start from zero in every block, so blocks are encoded independently. The block length and the three offsets are elaboration-time parameters.

Top module: `ara_encoder`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: in_ready stays 1 until K bits have been accepted. It then stays 0 until the final codeword beat is accepted. Bits offered while in_ready is 0 have no effect on any codeword.
- R3: Every codeword has exactly 2K beats, and out_last is 1 only on beat 2K-1 (beats are numbered from 0).
- R4: Beats 0 to K-1 carry the information bits u[0..K-1] in the order they were accepted.
- R5: The precoded bit is p[i] = u[i] for even i. For odd i it is the XOR of u[0] through u[i].
- R6: The interleaved stream of 3K bits is v[c*K+m] = p[(m + S_c) mod K] for c = 0, 1, 2 and m = 0..K-1. The offsets S_0, S_1 and S_2 are parameters.
- R7: Beat K+i carries the XOR of v[0] through v[3i+2], for i = 0..K-1.
- R8: Precoder and parity state start from zero in every block, so a codeword depends only on its own K information bits.
- R9: While out_valid is 1 and out_ready is 0, out_bit and out_last hold their values.
- R10: Once a block is full, out_valid stays 1 on every cycle until the final beat is accepted. With out_ready held high, one codeword bit leaves per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block buffer is accepting bits |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Codeword bit available |
| out_ready | input | 1 | Downstream accepts the codeword bit |
| out_bit | output | 1 | Codeword bit, systematic part first, then parity |
| out_last | output | 1 | Marks the final bit of a codeword |

## Verification
The K-th accepted input bit switches the block to output on the next clock edge. The first check of out_valid and in_ready after that bit is therefore due one cycle after its handshake. Each codeword bit, systematic or parity, is a registered-state function that depends on no input in the same cycle. Its value is due in the cycle in which it is presented, and the bench compares it when it sees the handshake. Inputs are driven and outputs are sampled on the falling edge, so each comparison covers the state left by the previous rising edge. A stalled beat is compared with the value held one cycle earlier, and the return of in_ready is checked one cycle after the last beat is accepted.

// File: rtl/ara_enc_pkg.sv
package ara_enc_pkg;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_EMIT = 1'b1
   } ara_phase_e;

   // circulant offset that belongs to a copy index of the repeated stream
   function automatic int unsigned ara_pick_shift(input int unsigned copy_idx,
                                                  input int unsigned s0,
                                                  input int unsigned s1,
                                                  input int unsigned s2);
      if (copy_idx == 0) return s0;
      if (copy_idx == 1) return s1;
      return s2;
   endfunction

endpackage

// File: rtl/ara_precoder.sv
module ara_precoder (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic blk_end,
   input  logic bit_in,
   input  logic odd_pos,
   output logic p_out
);
   logic run_q;
   logic run_d;

   assign run_d = run_q ^ bit_in;
   // odd positions take the running XOR, even positions pass the bit itself
   assign p_out = odd_pos ? run_d : bit_in;

   always_ff @(posedge clk) begin
      if (!rst_n)        run_q <= 1'b0;
      else if (step)     run_q <= blk_end ? 1'b0 : run_d;
   end
endmodule

// File: rtl/ara_circ_addr.sv
module ara_circ_addr #(
   parameter int unsigned K  = 16,
   parameter int unsigned S0 = 1,
   parameter int unsigned S1 = 5,
   parameter int unsigned S2 = 11,
   parameter int unsigned AW = $clog2(K)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic                restart,
   output logic [2:0][AW-1:0]  addr
);
   import ara_enc_pkg::*;

   localparam logic [AW:0] K_W = (AW+1)'(K);

   logic [1:0]    copy_q;
   logic [AW-1:0] pos_q;
   logic [AW:0]   pos_adv;

   // one address per tap of the three interleaved bits consumed per beat
   for (genvar t = 0; t < 3; t++) begin : g_tap
      logic [AW:0] m_raw;
      logic        wrap;
      logic [AW:0] m_loc;
      logic [1:0]  c_loc;
      logic [AW:0] sh;
      logic [AW:0] sum;

      always_comb begin
         m_raw = {1'b0, pos_q} + (AW+1)'(t);
         wrap  = (m_raw >= K_W);
         m_loc = wrap ? (m_raw - K_W) : m_raw;
         c_loc = copy_q + {1'b0, wrap};
         sh    = (AW+1)'(ara_pick_shift(32'(c_loc), S0, S1, S2));
         sum   = m_loc + sh;
         addr[t] = (sum >= K_W) ? AW'(sum - K_W) : AW'(sum);
      end
   end

   assign pos_adv = {1'b0, pos_q} + (AW+1)'(3);

   always_ff @(posedge clk) begin
      if (!rst_n || (step && restart)) begin
         copy_q <= 2'd0;
         pos_q  <= '0;
      end else if (step) begin
         if (pos_adv >= K_W) begin
            pos_q  <= AW'(pos_adv - K_W);
            copy_q <= copy_q + 2'd1;
         end else begin
            pos_q  <= AW'(pos_adv);
         end
      end
   end
endmodule

// File: rtl/ara_parity_acc.sv
module ara_parity_acc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       restart,
   input  logic [2:0] taps,
   output logic       par
);
   logic acc_q;

   // value after folding in three stream bits: the kept accumulator output
   assign par = acc_q ^ taps[0] ^ taps[1] ^ taps[2];

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= 1'b0;
      else if (step)   acc_q <= restart ? 1'b0 : par;
   end
endmodule

// File: rtl/ara_encoder.sv
module ara_encoder #(
   parameter int unsigned K  = 16,
   parameter int unsigned S0 = 1,
   parameter int unsigned S1 = 5,
   parameter int unsigned S2 = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic in_ready,
   input  logic in_bit,
   output logic out_valid,
   input  logic out_ready,
   output logic out_bit,
   output logic out_last
);
   import ara_enc_pkg::*;

   localparam int unsigned AW = $clog2(K);
   localparam int unsigned CW = $clog2(2*K);
   localparam logic [CW-1:0] FILL_LAST = CW'(K-1);
   localparam logic [CW-1:0] EMIT_LAST = CW'(2*K-1);
   localparam logic [CW-1:0] PAR_START = CW'(K);

   if (K < 3) begin : g_chk_k
      $error("ara_encoder: K must be at least 3");
   end
   if (S0 >= K || S1 >= K || S2 >= K) begin : g_chk_s
      $error("ara_encoder: circulant offsets must be below K");
   end

   ara_phase_e     phase_q;
   logic [CW-1:0]  cnt_q;
   logic [K-1:0]   ubuf_q;
   logic [K-1:0]   pbuf_q;

   logic fill_fire, emit_fire, fill_end, emit_end, in_parity;
   logic p_bit, par_bit, par_step;
   logic [2:0][AW-1:0] taddr;
   logic [2:0]         taps;

   assign in_ready  = (phase_q == PH_FILL);
   assign out_valid = (phase_q == PH_EMIT);
   assign fill_fire = in_valid && in_ready;
   assign emit_fire = out_valid && out_ready;
   assign fill_end  = fill_fire && (cnt_q == FILL_LAST);
   assign emit_end  = emit_fire && (cnt_q == EMIT_LAST);
   assign in_parity = (cnt_q >= PAR_START);
   assign par_step  = emit_fire && in_parity;

   ara_precoder u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (fill_fire),
      .blk_end (fill_end),
      .bit_in  (in_bit),
      .odd_pos (cnt_q[0]),
      .p_out   (p_bit)
   );

   ara_circ_addr #(.K(K), .S0(S0), .S1(S1), .S2(S2), .AW(AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (par_step),
      .restart (emit_end),
      .addr    (taddr)
   );

   for (genvar t = 0; t < 3; t++) begin : g_taps
      assign taps[t] = pbuf_q[taddr[t]];
   end

   ara_parity_acc u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (par_step),
      .restart (emit_end),
      .taps    (taps),
      .par     (par_bit)
   );

   assign out_bit  = in_parity ? par_bit : ubuf_q[cnt_q[AW-1:0]];
   assign out_last = out_valid && (cnt_q == EMIT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         cnt_q   <= '0;
         ubuf_q  <= '0;
         pbuf_q  <= '0;
      end else begin
         if (fill_fire) begin
            ubuf_q[cnt_q[AW-1:0]] <= in_bit;
            pbuf_q[cnt_q[AW-1:0]] <= p_bit;
            if (fill_end) begin
               phase_q <= PH_EMIT;
               cnt_q   <= '0;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
            end
         end
         if (emit_fire) begin
            if (emit_end) begin
               phase_q <= PH_FILL;
               cnt_q   <= '0;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ara_encoder_chk.sv
module ara_encoder_chk #(
   parameter int unsigned K = 16
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_ready,
   input logic out_bit,
   input logic out_last
);
   localparam int unsigned CW = $clog2(2*K) + 1;

   logic [CW-1:0] fcnt_q;
   logic [CW-1:0] bcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         bcnt_q <= '0;
      end else begin
         if (in_valid && in_ready)
            fcnt_q <= (fcnt_q == CW'(K-1)) ? '0 : fcnt_q + 1'b1;
         if (out_valid && out_ready)
            bcnt_q <= (bcnt_q == CW'(2*K-1)) ? '0 : bcnt_q + 1'b1;
      end
   end

   // R2: the K-th accepted bit closes the input
   a_r2_fill_close: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && fcnt_q == CW'(K-1)) |=> !in_ready);

   // R3: out_last appears only on the final beat position
   a_r3_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (bcnt_q == CW'(2*K-1)));

   // R3: the final beat position always carries out_last
   a_r3_last_due: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && bcnt_q == CW'(2*K-1)) |-> out_last);

   // R9: a stalled beat keeps its value
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

   // R10: no gap inside a codeword
   a_r10_stream: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> out_valid);

   // R2: input reopens right after the final beat
   a_r2_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
endmodule

bind ara_encoder ara_encoder_chk #(.K(K)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_bit   (out_bit),
   .out_last  (out_last)
);

// File: tb/ara_encoder_bench.sv
module ara_encoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int K  = 16;
   localparam int S0 = 1;
   localparam int S1 = 5;
   localparam int S2 = 11;
   localparam int NBLK = 24;
   localparam int WDOG = 100000;

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid, in_ready, in_bit;
   logic out_valid, out_ready, out_bit, out_last;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ara_encoder #(.K(K), .S0(S0), .S1(S1), .S2(S2)) u_ara_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_bit    (in_bit),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_bit   (out_bit),
      .out_last  (out_last)
   );

   function automatic int shift_of(input int c);
      return (c == 0) ? S0 : ((c == 1) ? S1 : S2);
   endfunction

   // expected codeword from R4..R7: index i holds beat i
   function automatic logic [2*K-1:0] ref_code(input logic [K-1:0] u);
      logic [K-1:0] p;
      logic [2*K-1:0] cw;
      logic run;
      logic acc;
      run = 1'b0;
      for (int i = 0; i < K; i++) begin
         run = run ^ u[i];
         p[i] = (i % 2 == 1) ? run : u[i];
         cw[i] = u[i];
      end
      acc = 1'b0;
      for (int j = 0; j < 3*K; j++) begin
         acc = acc ^ p[((j % K) + shift_of(j / K)) % K];
         if (j % 3 == 2) cw[K + j/3] = acc;
      end
      return cw;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic pattern_bit(input int blk, input int pos);
      case (blk)
         0: return 1'b0;
         1: return 1'b1;
         2: return (pos == 0);
         3: return (pos == K-1);
         4: return (pos % 2 == 1);
         default: return 1'($urandom);
      endcase
   endfunction

   initial begin
      logic [K-1:0] ubits;
      logic [2*K-1:0] exp_cw;
      bit holding;
      bit prev_stall;
      logic prev_bit, prev_last;
      int fillcnt, beat, blocks, cyc;
      void'($urandom(32'd4242));
      ubits = '0; exp_cw = '0;
      holding = 0; prev_stall = 0; prev_bit = 0; prev_last = 0;
      fillcnt = 0; beat = 0; blocks = 0; cyc = 0;
      rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
      check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);

      while (blocks < NBLK && cyc < WDOG) begin
         cyc++;
         // R2 / R10: input open and output busy follow the block state
         check(in_ready === !holding, "R2 in_ready", int'(in_ready), int'(!holding));
         check(out_valid === holding, "R10 out_valid", int'(out_valid), int'(holding));
         if (prev_stall) begin
            check(out_bit === prev_bit, "R9 out_bit hold", int'(out_bit), int'(prev_bit));
            check(out_last === prev_last, "R9 out_last hold", int'(out_last), int'(prev_last));
         end

         out_ready = (blocks % 4 == 0) ? 1'b1 : 1'(($urandom % 4) != 0);
         in_valid  = 1'(($urandom % 4) != 0);
         in_bit    = holding ? 1'($urandom) : pattern_bit(blocks, fillcnt);

         if (in_valid && in_ready) begin
            ubits[fillcnt] = in_bit;
            fillcnt++;
            if (fillcnt == K) begin
               exp_cw  = ref_code(ubits);
               holding = 1;
               fillcnt = 0;
            end
         end

         if (out_valid && out_ready) begin
            if (beat < K)
               check(out_bit === exp_cw[beat], "R4 systematic bit", int'(out_bit), int'(exp_cw[beat]));
            else
               check(out_bit === exp_cw[beat], "R7 parity bit (R5 R6 R8 chain)", int'(out_bit), int'(exp_cw[beat]));
            check(out_last === (beat == 2*K-1), "R3 out_last", int'(out_last), int'(beat == 2*K-1));
            beat++;
            if (beat == 2*K) begin
               beat = 0;
               holding = 0;
               blocks++;
            end
         end

         prev_stall = out_valid && !out_ready;
         prev_bit   = out_bit;
         prev_last  = out_last;
         @(negedge clk);
      end

      if (cyc >= WDOG) check(1'b0, "watchdog R10", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule